// File: doc/BRIEF.md
# USB Endpoint Data-Toggle Tracker

This block sits behind a USB device packet decoder. It follows the DATA0/DATA1 sequence bit of every endpoint for packets sent by the host. For each data packet that arrives with a good CRC, it decides whether the payload is new data to keep, or a retransmission to throw away and acknowledge once more. The toggle rule depends on the endpoint type. Bulk and interrupt endpoints treat a repeated PID as a host retry. A control endpoint restarts its sequence at every SETUP. An isochronous endpoint takes every packet.

Each endpoint has a small configuration: enable, a 2-bit type and a direction. Software writes it one endpoint at a time. A configuration event returns every expected toggle to DATA0. A hardware reset or a USB bus reset returns the block to the state after power-up, in which only endpoint 0 is usable and it works as a control endpoint. A per-endpoint status vector shows the PID of the last packet that each endpoint received.

Top module: `usb_toggle_tracker`

## Requirements
- R1: After `rst` every output is 0 and `tgl_status` is all zero. Endpoint 0 is enabled and of control type, and every other endpoint is disabled. All expected toggles are DATA0.
- R2: The `tgl_status` bit of an endpoint takes the PID of the last packet counted on that endpoint, accepted or duplicate, where 1 means DATA1 (`pkt_pid1`=1) and 0 means DATA0.
- R3: On a bulk endpoint (type 2'b10), a non-SETUP packet whose PID equals the expected toggle is accepted and flips the expected toggle. A packet with any other PID is a duplicate: `dis_valid` and `dup_flag` are raised and the expected toggle is left unchanged. `acc_valid` and `dup_flag` are never high together.
- R4: An interrupt endpoint (type 2'b11) follows exactly the same rules as R3.
- R5: On a control endpoint (type 2'b00), a SETUP packet is always accepted, even when it repeats, and the next expected toggle becomes DATA1. The later packets of the transfer follow R3, so a DATA1 status packet right after a SETUP is accepted.
- R6: On an isochronous endpoint (type 2'b01), every packet is accepted. It never causes a duplicate and never raises `hs_req`, and the toggle state has no effect on it.
- R7: `hs_req` is raised with every accepted packet on a non-isochronous endpoint and with every duplicate.
- R8: A `cfg_evt` pulse returns the expected toggle of every endpoint to DATA0 and leaves `tgl_status` unchanged. A packet strobed in the same cycle is ignored.
- R9: A packet is ignored when its endpoint is disabled, when `pkt_crc_ok` is 0, or when it targets a non-control endpoint whose direction is IN (`cfg_dir`=1). An ignored packet raises no output and changes no state.
- R10: A configuration write to endpoint 0 cannot disable it or change its type. Direction has no effect on a control endpoint.
- R11: The per-endpoint state updates on the clock edge that samples `pkt_stb`. `acc_valid`, `dis_valid`, `dup_flag` and `hs_req` are high for exactly the following cycle.
- R12: A `bus_reset` pulse has the same effect on configuration, toggles and status as `rst`.
- R13: A SETUP packet on a non-control endpoint raises only `dis_valid` and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_reset | input | 1 | USB bus reset event, one cycle |
| cfg_evt | input | 1 | Configuration event, clears all expected toggles |
| cfg_we | input | 1 | Endpoint configuration write strobe |
| cfg_ep | input | EPW | Endpoint being configured |
| cfg_en | input | 1 | Enable value to write |
| cfg_type | input | 2 | Type to write: 00 control, 01 isochronous, 10 bulk, 11 interrupt |
| cfg_dir | input | 1 | Direction to write: 1 IN, 0 OUT |
| pkt_stb | input | 1 | End of a received data packet |
| pkt_crc_ok | input | 1 | CRC of the packet was good |
| pkt_ep | input | EPW | Endpoint number of the packet |
| pkt_setup | input | 1 | Packet is the data of a SETUP transaction |
| pkt_pid1 | input | 1 | Data PID: 1 DATA1, 0 DATA0 |
| acc_valid | output | 1 | Packet accepted as new data |
| dis_valid | output | 1 | Packet discarded |
| dup_flag | output | 1 | Discard was a retransmission |
| hs_req | output | 1 | Request to send a handshake |
| tgl_status | output | NUM_EP | Last received PID per endpoint |

## Verification
The bench builds the block with the default NUM_EP = 8. With eight endpoints, all four endpoint types can sit on separate endpoints next to a disabled endpoint and an IN-direction endpoint. The cross-endpoint effects can therefore be seen: a configuration event, a bus reset, and an endpoint 0 rewrite that has to be ignored. A single walk through the vector table follows the toggle history of each endpoint across duplicates, bad-CRC packets and SETUP resynchronisation. Directed tests then cover the same-cycle collision of a packet with a configuration event, the one-cycle width of the outputs, and the state after a bus reset.

// File: rtl/usb_tgl_pkg.sv
package usb_tgl_pkg;

  typedef enum logic [1:0] {
    EP_CTRL = 2'b00,
    EP_ISO  = 2'b01,
    EP_BULK = 2'b10,
    EP_INTR = 2'b11
  } ep_kind_e;

  typedef struct packed {
    logic accept;
    logic discard;
    logic dup;
    logic hs;
    logic exp_we;
    logic nxt_exp;
    logic rx;
  } verdict_t;

endpackage

// File: rtl/usb_tgl_cfg.sv
module usb_tgl_cfg #(
  parameter int NUM_EP = 8,
  localparam int EPW = $clog2(NUM_EP)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   bus_reset,
  input  logic                   cfg_we,
  input  logic [EPW-1:0]         cfg_ep,
  input  logic                   cfg_en,
  input  logic [1:0]             cfg_type,
  input  logic                   cfg_dir,
  output logic [NUM_EP-1:0]      en_o,
  output logic [NUM_EP-1:0][1:0] kind_o,
  output logic [NUM_EP-1:0]      dir_o
);
  import usb_tgl_pkg::*;

  // endpoint 0 is hard-wired as an enabled control endpoint
  assign en_o[0]   = 1'b1;
  assign kind_o[0] = EP_CTRL;
  assign dir_o[0]  = 1'b0;

  for (genvar g = 1; g < NUM_EP; g++) begin : g_ep
    logic       en_q;
    logic [1:0] kind_q;
    logic       dir_q;

    always_ff @(posedge clk) begin
      if (rst || bus_reset) begin
        en_q   <= 1'b0;
        kind_q <= EP_CTRL;
        dir_q  <= 1'b0;
      end else if (cfg_we && cfg_ep == EPW'(g)) begin
        en_q   <= cfg_en;
        kind_q <= cfg_type;
        dir_q  <= cfg_dir;
      end
    end

    assign en_o[g]   = en_q;
    assign kind_o[g] = kind_q;
    assign dir_o[g]  = dir_q;
  end

endmodule

// File: rtl/usb_tgl_decide.sv
module usb_tgl_decide (
  input  logic                  stb,
  input  logic                  crc_ok,
  input  logic                  block,
  input  logic                  setup,
  input  logic                  pid1,
  input  logic                  en,
  input  usb_tgl_pkg::ep_kind_e kind,
  input  logic                  dir_in,
  input  logic                  exp,
  output usb_tgl_pkg::verdict_t vd
);
  import usb_tgl_pkg::*;

  logic live;
  logic dir_bad;

  assign live    = stb && crc_ok && en && !block;
  assign dir_bad = (kind != EP_CTRL) && dir_in;

  always_comb begin
    vd = '0;
    if (live && !dir_bad) begin
      if (setup) begin
        if (kind == EP_CTRL) begin
          vd.accept  = 1'b1;
          vd.hs      = 1'b1;
          vd.exp_we  = 1'b1;
          vd.nxt_exp = 1'b1;
          vd.rx      = 1'b1;
        end else begin
          vd.discard = 1'b1;
        end
      end else if (kind == EP_ISO) begin
        vd.accept = 1'b1;
        vd.rx     = 1'b1;
      end else if (pid1 == exp) begin
        vd.accept  = 1'b1;
        vd.hs      = 1'b1;
        vd.exp_we  = 1'b1;
        vd.nxt_exp = !exp;
        vd.rx      = 1'b1;
      end else begin
        vd.discard = 1'b1;
        vd.dup     = 1'b1;
        vd.hs      = 1'b1;
        vd.rx      = 1'b1;
      end
    end
  end

endmodule

// File: rtl/usb_tgl_state.sv
module usb_tgl_state #(
  parameter int NUM_EP = 8,
  localparam int EPW = $clog2(NUM_EP)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_reset,
  input  logic              cfg_evt,
  input  logic [EPW-1:0]    ep,
  input  logic              exp_we,
  input  logic              nxt_exp,
  input  logic              rx,
  input  logic              pid1,
  output logic [NUM_EP-1:0] exp_o,
  output logic [NUM_EP-1:0] sts_o
);

  for (genvar g = 0; g < NUM_EP; g++) begin : g_ep
    logic hit;
    assign hit = (ep == EPW'(g));

    always_ff @(posedge clk) begin
      if (rst || bus_reset) begin
        exp_o[g] <= 1'b0;
        sts_o[g] <= 1'b0;
      end else begin
        if (cfg_evt)
          exp_o[g] <= 1'b0;
        else if (exp_we && hit)
          exp_o[g] <= nxt_exp;
        if (rx && hit)
          sts_o[g] <= pid1;
      end
    end
  end

  // R8: a configuration event leaves every expected toggle at DATA0
  p_cfg_clear_r8: assert property (@(posedge clk) disable iff (rst)
    (cfg_evt && !bus_reset) |=> (exp_o == '0));

  // R12: a bus reset clears toggles and status
  p_bus_clear_r12: assert property (@(posedge clk) disable iff (rst)
    bus_reset |=> (exp_o == '0 && sts_o == '0));

endmodule

// File: rtl/usb_toggle_tracker.sv
module usb_toggle_tracker #(
  parameter int NUM_EP = 8,
  localparam int EPW = $clog2(NUM_EP)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_reset,
  input  logic              cfg_evt,
  input  logic              cfg_we,
  input  logic [EPW-1:0]    cfg_ep,
  input  logic              cfg_en,
  input  logic [1:0]        cfg_type,
  input  logic              cfg_dir,
  input  logic              pkt_stb,
  input  logic              pkt_crc_ok,
  input  logic [EPW-1:0]    pkt_ep,
  input  logic              pkt_setup,
  input  logic              pkt_pid1,
  output logic              acc_valid,
  output logic              dis_valid,
  output logic              dup_flag,
  output logic              hs_req,
  output logic [NUM_EP-1:0] tgl_status
);
  import usb_tgl_pkg::*;

  logic [NUM_EP-1:0]      en_w;
  logic [NUM_EP-1:0][1:0] kind_w;
  logic [NUM_EP-1:0]      dir_w;
  logic [NUM_EP-1:0]      exp_w;
  ep_kind_e               kind_sel;
  verdict_t               vd;

  usb_tgl_cfg #(.NUM_EP(NUM_EP)) u_cfg (
    .clk      (clk),
    .rst      (rst),
    .bus_reset(bus_reset),
    .cfg_we   (cfg_we),
    .cfg_ep   (cfg_ep),
    .cfg_en   (cfg_en),
    .cfg_type (cfg_type),
    .cfg_dir  (cfg_dir),
    .en_o     (en_w),
    .kind_o   (kind_w),
    .dir_o    (dir_w)
  );

  assign kind_sel = ep_kind_e'(kind_w[pkt_ep]);

  usb_tgl_decide u_decide (
    .stb    (pkt_stb),
    .crc_ok (pkt_crc_ok),
    .block  (bus_reset || cfg_evt),
    .setup  (pkt_setup),
    .pid1   (pkt_pid1),
    .en     (en_w[pkt_ep]),
    .kind   (kind_sel),
    .dir_in (dir_w[pkt_ep]),
    .exp    (exp_w[pkt_ep]),
    .vd     (vd)
  );

  usb_tgl_state #(.NUM_EP(NUM_EP)) u_state (
    .clk      (clk),
    .rst      (rst),
    .bus_reset(bus_reset),
    .cfg_evt  (cfg_evt),
    .ep       (pkt_ep),
    .exp_we   (vd.exp_we),
    .nxt_exp  (vd.nxt_exp),
    .rx       (vd.rx),
    .pid1     (pkt_pid1),
    .exp_o    (exp_w),
    .sts_o    (tgl_status)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_valid <= 1'b0;
      dis_valid <= 1'b0;
      dup_flag  <= 1'b0;
      hs_req    <= 1'b0;
    end else begin
      acc_valid <= vd.accept;
      dis_valid <= vd.discard;
      dup_flag  <= vd.dup;
      hs_req    <= vd.hs;
    end
  end

  // R3: a packet is never both new and a retransmission
  p_acc_dup_excl_r3: assert property (@(posedge clk) disable iff (rst)
    !(acc_valid && dup_flag));

  // R11: a decision only follows a good-CRC strobe one cycle earlier
  p_one_cycle_r11: assert property (@(posedge clk) disable iff (rst)
    (acc_valid || dis_valid) |-> $past(pkt_stb && pkt_crc_ok));

  // R7: a duplicate is discarded and still acknowledged
  p_dup_hs_r7: assert property (@(posedge clk) disable iff (rst)
    dup_flag |-> (hs_req && dis_valid));

  // R6: isochronous packets get no handshake
  p_iso_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && $past(kind_sel == EP_ISO)) |-> !hs_req);

endmodule

// File: tb/usb_toggle_tracker_test.sv
module usb_toggle_tracker_test;

  localparam int NUM_EP = 8;
  localparam int EPW = $clog2(NUM_EP);

  localparam logic [1:0] OP_PKT = 2'd0;
  localparam logic [1:0] OP_CFG = 2'd1;
  localparam logic [1:0] OP_EVT = 2'd2;

  // expected decision bits {acc, dis, dup, hs}
  localparam logic [3:0] X_NONE = 4'b0000;
  localparam logic [3:0] X_ACK  = 4'b1001;
  localparam logic [3:0] X_ACC  = 4'b1000;
  localparam logic [3:0] X_DUP  = 4'b0111;
  localparam logic [3:0] X_DIS  = 4'b0100;

  typedef struct packed {
    logic [1:0] op;
    logic [2:0] ep;
    logic       a;   // PKT: setup / CFG: enable
    logic       b;   // PKT: pid1  / CFG: dir
    logic       c;   // PKT: crc ok
    logic [1:0] t;   // CFG: type
    logic [3:0] ex;
    logic       st;
    logic [3:0] rq;
  } vec_t;

  localparam int NV = 36;
  localparam vec_t TBL [NV] = '{
    {OP_CFG, 3'd1, 1'b1, 1'b0, 1'b0, 2'b10, X_NONE, 1'b0, 4'd3},  // R3 ep1 bulk
    {OP_CFG, 3'd2, 1'b1, 1'b0, 1'b0, 2'b11, X_NONE, 1'b0, 4'd4},  // R4 ep2 interrupt
    {OP_CFG, 3'd3, 1'b1, 1'b0, 1'b0, 2'b01, X_NONE, 1'b0, 4'd6},  // R6 ep3 iso
    {OP_CFG, 3'd4, 1'b1, 1'b1, 1'b0, 2'b10, X_NONE, 1'b0, 4'd9},  // R9 ep4 bulk IN
    {OP_CFG, 3'd5, 1'b0, 1'b0, 1'b0, 2'b10, X_NONE, 1'b0, 4'd9},  // R9 ep5 disabled
    {OP_PKT, 3'd1, 1'b0, 1'b0, 1'b1, 2'b00, X_ACK,  1'b0, 4'd3},  // R3 D0 new
    {OP_PKT, 3'd1, 1'b0, 1'b1, 1'b1, 2'b00, X_ACK,  1'b1, 4'd3},  // R3 D1 new
    {OP_PKT, 3'd1, 1'b0, 1'b1, 1'b1, 2'b00, X_DUP,  1'b1, 4'd3},  // R3 D1 repeat
    {OP_PKT, 3'd1, 1'b0, 1'b0, 1'b1, 2'b00, X_ACK,  1'b0, 4'd3},  // R3 D0 new
    {OP_PKT, 3'd1, 1'b0, 1'b0, 1'b1, 2'b00, X_DUP,  1'b0, 4'd2},  // R2 status on dup
    {OP_PKT, 3'd2, 1'b0, 1'b1, 1'b1, 2'b00, X_DUP,  1'b1, 4'd4},  // R4 D1 while D0 expected
    {OP_PKT, 3'd2, 1'b0, 1'b0, 1'b1, 2'b00, X_ACK,  1'b0, 4'd4},  // R4
    {OP_PKT, 3'd2, 1'b0, 1'b1, 1'b1, 2'b00, X_ACK,  1'b1, 4'd4},  // R4
    {OP_PKT, 3'd3, 1'b0, 1'b1, 1'b1, 2'b00, X_ACC,  1'b1, 4'd6},  // R6 no handshake
    {OP_PKT, 3'd3, 1'b0, 1'b1, 1'b1, 2'b00, X_ACC,  1'b1, 4'd6},  // R6 repeat accepted
    {OP_PKT, 3'd3, 1'b0, 1'b0, 1'b1, 2'b00, X_ACC,  1'b0, 4'd6},  // R6
    {OP_PKT, 3'd0, 1'b1, 1'b0, 1'b1, 2'b00, X_ACK,  1'b0, 4'd5},  // R5 setup
    {OP_PKT, 3'd0, 1'b0, 1'b1, 1'b1, 2'b00, X_ACK,  1'b1, 4'd5},  // R5 data D1
    {OP_PKT, 3'd0, 1'b0, 1'b0, 1'b1, 2'b00, X_ACK,  1'b0, 4'd5},  // R5 data D0
    {OP_PKT, 3'd0, 1'b0, 1'b0, 1'b1, 2'b00, X_DUP,  1'b0, 4'd5},  // R5 repeat
    {OP_PKT, 3'd0, 1'b1, 1'b0, 1'b1, 2'b00, X_ACK,  1'b0, 4'd5},  // R5 setup resync
    {OP_PKT, 3'd0, 1'b0, 1'b1, 1'b1, 2'b00, X_ACK,  1'b1, 4'd5},  // R5 status D1
    {OP_PKT, 3'd0, 1'b1, 1'b0, 1'b1, 2'b00, X_ACK,  1'b0, 4'd5},  // R5 setup
    {OP_PKT, 3'd0, 1'b1, 1'b0, 1'b1, 2'b00, X_ACK,  1'b0, 4'd5},  // R5 repeated setup
    {OP_PKT, 3'd4, 1'b0, 1'b0, 1'b1, 2'b00, X_NONE, 1'b0, 4'd9},  // R9 IN endpoint
    {OP_PKT, 3'd5, 1'b0, 1'b0, 1'b1, 2'b00, X_NONE, 1'b0, 4'd9},  // R9 disabled
    {OP_PKT, 3'd1, 1'b0, 1'b1, 1'b0, 2'b00, X_NONE, 1'b0, 4'd9},  // R9 bad CRC
    {OP_PKT, 3'd1, 1'b0, 1'b1, 1'b1, 2'b00, X_ACK,  1'b1, 4'd9},  // R9 toggle untouched
    {OP_PKT, 3'd1, 1'b1, 1'b0, 1'b1, 2'b00, X_DIS,  1'b1, 4'd13}, // R13 setup on bulk
    {OP_PKT, 3'd1, 1'b0, 1'b0, 1'b1, 2'b00, X_ACK,  1'b0, 4'd13}, // R13 toggle untouched
    {OP_EVT, 3'd0, 1'b0, 1'b0, 1'b0, 2'b00, X_NONE, 1'b0, 4'd8},  // R8 config event
    {OP_PKT, 3'd1, 1'b0, 1'b0, 1'b1, 2'b00, X_ACK,  1'b0, 4'd8},  // R8 back to D0
    {OP_CFG, 3'd0, 1'b0, 1'b1, 1'b0, 2'b10, X_NONE, 1'b0, 4'd10}, // R10 rewrite ep0
    {OP_PKT, 3'd0, 1'b0, 1'b0, 1'b1, 2'b00, X_ACK,  1'b0, 4'd10}, // R10 still enabled
    {OP_PKT, 3'd0, 1'b1, 1'b0, 1'b1, 2'b00, X_ACK,  1'b0, 4'd10}, // R10 still control
    {OP_PKT, 3'd0, 1'b0, 1'b1, 1'b1, 2'b00, X_ACK,  1'b1, 4'd10}  // R10
  };

  logic clk = 1'b0;
  logic rst, bus_reset, cfg_evt, cfg_we, cfg_en, cfg_dir;
  logic [EPW-1:0] cfg_ep, pkt_ep;
  logic [1:0] cfg_type;
  logic pkt_stb, pkt_crc_ok, pkt_setup, pkt_pid1;
  logic acc_valid, dis_valid, dup_flag, hs_req;
  logic [NUM_EP-1:0] tgl_status;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  usb_toggle_tracker #(.NUM_EP(NUM_EP)) uut (
    .clk(clk), .rst(rst), .bus_reset(bus_reset), .cfg_evt(cfg_evt),
    .cfg_we(cfg_we), .cfg_ep(cfg_ep), .cfg_en(cfg_en), .cfg_type(cfg_type),
    .cfg_dir(cfg_dir), .pkt_stb(pkt_stb), .pkt_crc_ok(pkt_crc_ok),
    .pkt_ep(pkt_ep), .pkt_setup(pkt_setup), .pkt_pid1(pkt_pid1),
    .acc_valid(acc_valid), .dis_valid(dis_valid), .dup_flag(dup_flag),
    .hs_req(hs_req), .tgl_status(tgl_status)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send_pkt(input logic [EPW-1:0] ep, input logic setup,
                          input logic pid1, input logic crc, input logic with_evt);
    @(negedge clk);
    pkt_stb = 1'b1; pkt_ep = ep; pkt_setup = setup; pkt_pid1 = pid1;
    pkt_crc_ok = crc; cfg_evt = with_evt;
    @(negedge clk);
    pkt_stb = 1'b0; pkt_setup = 1'b0; pkt_pid1 = 1'b0; cfg_evt = 1'b0;
  endtask

  task automatic cfg_write(input logic [EPW-1:0] ep, input logic en,
                           input logic [1:0] ty, input logic dir);
    @(negedge clk);
    cfg_we = 1'b1; cfg_ep = ep; cfg_en = en; cfg_type = ty; cfg_dir = dir;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic pulse_evt();
    @(negedge clk);
    cfg_evt = 1'b1;
    @(negedge clk);
    cfg_evt = 1'b0;
  endtask

  function automatic logic [3:0] outs();
    return {acc_valid, dis_valid, dup_flag, hs_req};
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; bus_reset = 1'b0; cfg_evt = 1'b0; cfg_we = 1'b0;
    cfg_ep = '0; cfg_en = 1'b0; cfg_type = 2'b00; cfg_dir = 1'b0;
    pkt_stb = 1'b0; pkt_crc_ok = 1'b0; pkt_ep = '0; pkt_setup = 1'b0; pkt_pid1 = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state
    check("R1 outputs after reset", 32'(outs()), 32'h0);
    check("R1 status after reset", 32'(tgl_status), 32'h0);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = TBL[i];
      case (v.op)
        OP_CFG: cfg_write(EPW'(v.ep), v.a, v.t, v.b);
        OP_EVT: pulse_evt();
        default: begin
          send_pkt(EPW'(v.ep), v.a, v.b, v.c, 1'b0);
          check($sformatf("R%0d row %0d decision", v.rq, i), 32'(outs()), 32'(v.ex));
          check($sformatf("R%0d row %0d status", v.rq, i),
                32'(tgl_status[v.ep]), 32'(v.st));
        end
      endcase
    end

    // R2 / R8: status bits survive the configuration event
    check("R2 status vector", 32'(tgl_status), 32'h05);

    // R11: decision lasts a single cycle
    send_pkt(EPW'(2), 1'b0, 1'b0, 1'b1, 1'b0);
    check("R11 decision cycle", 32'(outs()), 32'(X_ACK));
    @(negedge clk);
    check("R11 decision gone", 32'(outs()), 32'h0);

    // R8: packet colliding with a configuration event is ignored
    send_pkt(EPW'(1), 1'b0, 1'b1, 1'b1, 1'b1);
    check("R8 collided packet", 32'(outs()), 32'h0);
    check("R8 collided status", 32'(tgl_status[1]), 32'h0);
    send_pkt(EPW'(1), 1'b0, 1'b0, 1'b1, 1'b0);
    check("R8 DATA0 after event", 32'(outs()), 32'(X_ACK));

    // R12: bus reset
    @(negedge clk);
    bus_reset = 1'b1;
    @(negedge clk);
    bus_reset = 1'b0;
    check("R12 status cleared", 32'(tgl_status), 32'h0);
    send_pkt(EPW'(1), 1'b0, 1'b0, 1'b1, 1'b0);
    check("R12 ep1 disabled", 32'(outs()), 32'h0);
    send_pkt(EPW'(0), 1'b0, 1'b0, 1'b1, 1'b0);
    check("R12 ep0 control at DATA0", 32'(outs()), 32'(X_ACK));
    send_pkt(EPW'(0), 1'b0, 1'b0, 1'b1, 1'b0);
    check("R12 ep0 repeat", 32'(outs()), 32'(X_DUP));

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule